// File: doc/BRIEF.md
# Quarter-Rate IF Digital Upconverter

This block takes a complex baseband stream (I and Q) and turns it into a real intermediate-frequency sample stream for a D/A converter. The clock and the output sample rate are both 100 MHz. The carrier sits at 25 MHz, exactly one quarter of the clock. The incoming samples already carry a signal about 20 MHz wide and have been pulse-shaped at 5x oversampling upstream, so this block only translates them in frequency.

A carrier at a quarter of the sample rate has only four phases: 0, 90, 180 and 270 degrees. Its cosine and sine therefore take only the values 0, +1 and -1. The mixer needs no oscillator table and no multipliers. A two-bit phase counter picks I, the negated Q, the negated I or Q on successive clocks. Negation saturates, so the most negative input cannot wrap around. One real sample leaves the block on every clock through an output register.

When the input valid flag is low the block sends zeros, but the carrier phase keeps advancing. The carrier therefore stays continuous across gaps in the stream.

Top module: `quad_if_upconv`

## Requirements
- R1: While reset is high the output register holds zero. The phase counter is cleared, so the first input sampled after reset is released is sent out in phase 0.
- R2: In phase 0 the output equals the I input.
- R3: In phase 1 the output equals the Q input negated, with saturation.
- R4: In phase 2 the output equals the I input negated, with saturation.
- R5: In phase 3 the output equals the Q input unchanged.
- R6: Negating the most negative two's-complement value, -2^(W-1), gives the most positive value, 2^(W-1)-1. No negated result ever wraps to the most negative code.
- R7: The output is registered. The inputs sampled at a clock edge appear at the output right after that edge and stay there until the next edge, a latency of one clock.
- R8: When the valid input is low at an edge, the output after that edge is zero whatever I and Q are.
- R9: Outside reset the phase advances by one at every clock edge, wrapping from 3 back to 0, and valid does not affect this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when in_i / in_q carry a baseband sample |
| in_i | input | DATA_W | In-phase baseband sample, signed two's complement |
| in_q | input | DATA_W | Quadrature baseband sample, signed two's complement |
| if_out | output | DATA_W | Real IF sample for the D/A converter, signed |

## Verification
The only internal state is the two-bit phase counter. If it were off by one it would swap or negate the output on the very next valid sample. The output would show the wrong selection of I or Q, or the wrong sign, within one clock after reset is released or after a gap in valid. A counter that stalled while valid is low would show up on the first sample after the gap, because that sample would come out in the phase it would have had if there were no gap. The bench keeps its own count of edges since reset and checks each output against I, -Q, -I, +Q in that order. It also checks the saturation corner on both the I and the Q path, and checks that the output does not change before the edge that registers it.

// File: rtl/quc_pkg.sv
package quc_pkg;

  // Carrier phase at a quarter of the sample rate.
  // Each value names the term that is sent out in that phase.
  typedef enum logic [1:0] {
    PH_POS_I = 2'd0,
    PH_NEG_Q = 2'd1,
    PH_NEG_I = 2'd2,
    PH_POS_Q = 2'd3
  } quc_phase_e;

  localparam int unsigned QUC_PHASES = 4;

endpackage

// File: rtl/quc_phase_gen.sv
module quc_phase_gen
  import quc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output quc_phase_e phase
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= 2'd0;
    end else begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign phase = quc_phase_e'(cnt_q);

  // R1: reset clears the phase
  a_r1_phase_cleared : assert property (@(posedge clk)
    rst |=> (cnt_q == 2'd0));

  // R9: the phase advances by one at every edge, whatever valid is
  a_r9_phase_step : assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

endmodule

// File: rtl/quc_sat_neg.sv
module quc_sat_neg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);

  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (din == MIN_V) begin
      dout = MAX_V;
    end else begin
      dout = -din;
    end
  end

endmodule

// File: rtl/quc_rot_mux.sv
module quc_rot_mux
  import quc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  quc_phase_e               phase,
  input  logic signed [DATA_W-1:0] pos_i,
  input  logic signed [DATA_W-1:0] pos_q,
  input  logic signed [DATA_W-1:0] neg_i,
  input  logic signed [DATA_W-1:0] neg_q,
  output logic signed [DATA_W-1:0] sel
);

  always_comb begin
    unique case (phase)
      PH_POS_I: sel = pos_i;
      PH_NEG_Q: sel = neg_q;
      PH_NEG_I: sel = neg_i;
      PH_POS_Q: sel = pos_q;
      default:  sel = '0;
    endcase
  end

endmodule

// File: rtl/quad_if_upconv.sv
module quad_if_upconv
  import quc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] if_out
);

  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  quc_phase_e               phase;
  logic signed [DATA_W-1:0] s_i, s_q, n_i, n_q, mixed;
  logic signed [DATA_W-1:0] out_q;

  assign s_i = in_i;
  assign s_q = in_q;

  quc_phase_gen u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  quc_sat_neg #(.DATA_W(DATA_W)) u_neg_i (
    .din  (s_i),
    .dout (n_i)
  );

  quc_sat_neg #(.DATA_W(DATA_W)) u_neg_q (
    .din  (s_q),
    .dout (n_q)
  );

  quc_rot_mux #(.DATA_W(DATA_W)) u_mux (
    .phase (phase),
    .pos_i (s_i),
    .pos_q (s_q),
    .neg_i (n_i),
    .neg_q (n_q),
    .sel   (mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (in_valid) begin
      out_q <= mixed;
    end else begin
      out_q <= '0;
    end
  end

  assign if_out = out_q;

  // R1: reset leaves the output at zero
  a_r1_reset_zero : assert property (@(posedge clk)
    rst |=> (if_out == '0));

  // R8: an idle input gives a zero output
  a_r8_idle_zero : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (if_out == '0));

  // R2, R7: phase 0 passes I through one clock later
  a_r2_pass_i : assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_POS_I) |=> (if_out == $past(in_i)));

  // R5: phase 3 passes Q through
  a_r5_pass_q : assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_POS_Q) |=> (if_out == $past(in_q)));

  // R3: phase 1 sends -Q when Q is not the extreme code
  a_r3_neg_q : assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_NEG_Q && s_q != MIN_V)
      |=> ($signed(if_out) == -$signed($past(in_q))));

  // R4: phase 2 sends -I when I is not the extreme code
  a_r4_neg_i : assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_NEG_I && s_i != MIN_V)
      |=> ($signed(if_out) == -$signed($past(in_i))));

  // R6: the extreme code saturates on either path
  a_r6_no_overflow : assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((phase == PH_NEG_I && s_i == MIN_V) ||
                  (phase == PH_NEG_Q && s_q == MIN_V)))
      |=> (if_out == MAX_V));

endmodule

// File: tb/sim_quad_if_upconv.sv
module sim_quad_if_upconv;

  localparam int W = 16;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_i = '0;
  logic [W-1:0] in_q = '0;
  logic [W-1:0] if_out;

  int n_tests = 0;
  int n_fail  = 0;
  int tb_ph   = 0;
  logic [W-1:0] last_exp = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_if_upconv #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .if_out(if_out)
  );

  function automatic logic [W-1:0] sneg(input logic [W-1:0] x);
    if (x == MINV) return MAXV;
    return W'(-$signed(x));
  endfunction

  function automatic logic [W-1:0] model(input int ph, input logic v,
                                         input logic [W-1:0] i, input logic [W-1:0] q);
    if (!v) return '0;
    case (ph % 4)
      0: return i;
      1: return sneg(q);
      2: return sneg(i);
      default: return q;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one sample now (just after a falling edge) and check it after the
  // next rising edge. The check before the edge covers R7. Ends at a falling edge.
  task automatic step(input string req, input logic v, input logic [W-1:0] i, input logic [W-1:0] q);
    logic [W-1:0] e;
    in_valid = v; in_i = i; in_q = q;
    e = model(tb_ph, v, i, q);
    #1;
    check("R7 (held until edge)", if_out, last_exp);
    @(posedge clk); #1;
    check(req, if_out, e);
    last_exp = e;
    tb_ph++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_i = 16'h1234; in_q = 16'h4321;
    repeat (3) @(posedge clk);
    #1 check("R1 output zero in reset", if_out, '0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    tb_ph = 0; last_exp = '0;
  endtask

  task automatic t_first_after_reset();
    t_reset();
    step("R1 first sample in phase 0", 1'b1, 16'h0AB0, 16'h7001);
  endtask

  task automatic t_rotation();
    t_reset();
    step("R2 phase 0 = I",  1'b1, 16'h0123, 16'h0456);
    step("R3 phase 1 = -Q", 1'b1, 16'h0123, 16'h0456);
    step("R4 phase 2 = -I", 1'b1, 16'h0123, 16'h0456);
    step("R5 phase 3 = +Q", 1'b1, 16'h0123, 16'h0456);
    step("R9 wrap to phase 0", 1'b1, 16'hF000, 16'h0FFF);
    for (int k = 0; k < 16; k++)
      step("R9 rotation sweep", 1'b1, W'(k * 16'h1357 - 16'h4000), W'(16'h2222 - k * 16'h0BCD));
  endtask

  task automatic t_saturation();
    t_reset();
    step("R2 extreme I kept", 1'b1, MINV, MINV);
    step("R6 extreme Q negated", 1'b1, 16'h0001, MINV);
    step("R6 extreme I negated", 1'b1, MINV, 16'h0001);
    step("R5 extreme Q kept", 1'b1, 16'h0000, MINV);
    step("R2 max I kept", 1'b1, MAXV, MAXV);
    step("R3 max Q negated", 1'b1, MAXV, MAXV);
    step("R4 max I negated", 1'b1, MAXV, MAXV);
  endtask

  task automatic t_idle();
    t_reset();
    step("R2 before gap", 1'b1, 16'h0100, 16'h0200);
    step("R8 idle zero", 1'b0, 16'h7777, 16'h5555);
    step("R8 idle zero", 1'b0, 16'h8001, 16'h1111);
    // phase ran on through the gap: this sample lands in phase 3
    step("R9 phase kept running (+Q)", 1'b1, 16'h0100, 16'h0200);
    step("R9 next is phase 0", 1'b1, 16'h0100, 16'h0200);
    step("R8 idle zero single", 1'b0, 16'hFFFF, 16'hFFFF);
    step("R4 after single gap", 1'b1, 16'h0100, 16'h0200);
  endtask

  task automatic t_mid_reset();
    t_reset();
    step("R2 pre-reset", 1'b1, 16'h0011, 16'h0022);
    step("R3 pre-reset", 1'b1, 16'h0011, 16'h0022);
    t_reset();
    step("R1 phase restarts at 0", 1'b1, 16'h0033, 16'h0044);
    step("R3 after restart", 1'b1, 16'h0033, 16'h0044);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_first_after_reset();
    t_rotation();
    t_saturation();
    t_idle();
    t_mid_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule